// File: doc/BRIEF.md
# Sticky-Status Interrupt Aggregator

This block gathers up to 32 interrupt request lines into one interrupt output. The 16 lowest lines are fixed sources. Each of them is active-high and is caught on a rising edge. Between 0 and 16 further lines are external sources. Parameters give each external line its polarity (active-high or active-low) and its trigger mode (edge or level).

Every line passes through a two-flop synchronizer and is turned into an active-high signal. It is then captured into a sticky status bit. An edge-mode line sets its bit when its normalized value rises. A level-mode line sets its bit on every cycle its normalized value is high. The status bits are masked by an enable register to give the pending bits. The interrupt output is high whenever any pending bit is set.

Software reaches the registers through a plain port: write strobe, word address, write data and combinational read data. Writing ones to the acknowledge address clears the matching status bits. A level-mode line that is still active sets its bit again in that same cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, status, pending and enable all read 0 and `irq_out` is 0.
- R2: Pending (address 1) reads as status AND enable, bit for bit. Bit i of every register belongs to source i. `irq_out` is 1 exactly when pending is nonzero.
- R3: A write to enable (address 2) changes pending and `irq_out` from the clock edge that takes the write. There is no further delay.
- R4: An edge-mode source sets its status bit (address 0) only when its normalized value goes from 0 to 1. The bit stays set after the line returns to idle. Holding the line active after an acknowledge does not set it again.
- R5: A level-mode source sets its status bit while its normalized value is 1.
- R6: External source 16+k is active-high when polarity bit k is 1 and active-low when it is 0. It is edge-mode when trigger bit k is 1. Sources 0..15 are always rising-edge, active-high.
- R7: A write to acknowledge (address 3) clears only those status bits that are written as 1. All other status bits keep their values.
- R8: A level-mode source whose normalized value is still 1 when it is acknowledged reads back as set right after the write.
- R9: Acknowledge reads 0. Writes to status and pending change no register.
- R10: Bits at and above 16+EXT_COUNT read 0 in every register. They cannot raise `irq_out`, even when written as 1 into enable.
- R11: A change on a source line first shows in status after the third rising clock edge following the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 16+EXT_COUNT | Raw interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 pending, 2 enable, 3 acknowledge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong synchronizer or edge-history flop moves the status set one cycle off the third-edge point. It can also make an acknowledged edge source set again while its line is held, which shows at the status address within three cycles. A corrupted status or enable bit shows at once in the pending read and on `irq_out`. The enable write is visible on the very next sample, so a delayed or dropped update is caught in that cycle. A bad acknowledge mask shows as a neighbouring bit lost or kept in the status read right after the write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W  = 32;
    localparam int FIXED  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 2'd0,
        ADR_PEND   = 2'd1,
        ADR_ENABLE = 2'd2,
        ADR_ACK    = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/irq_input_sync.sv
// Two-flop synchronizer per line, then polarity normalization to active-high.
// Flops reset to each line's inactive level so no false event follows reset.
module irq_input_sync #(
    parameter int           N        = 24,
    parameter logic [N-1:0] ACT_HIGH = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] norm
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= ~ACT_HIGH[i];
                sync_q[i] <= ~ACT_HIGH[i];
            end else begin
                meta_q[i] <= raw[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign norm = sync_q ^ ~ACT_HIGH;

endmodule

// File: rtl/irq_capture.sv
// Turns normalized lines into per-cycle set requests: rising edge or level.
module irq_capture #(
    parameter int           N         = 24,
    parameter logic [N-1:0] EDGE_MODE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] norm,
    output logic [N-1:0] set_vec
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= norm;
    end

    for (genvar i = 0; i < N; i++) begin : g_mode
        if (EDGE_MODE[i]) begin : g_edge
            assign set_vec[i] = norm[i] & ~prev_q[i];
        end else begin : g_level
            assign set_vec[i] = norm[i];
        end
    end

    // An edge-mode request never follows a cycle where the line was already high.
    assert_edge_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & EDGE_MODE & $past(norm)) == '0));

endmodule

// File: rtl/irq_regs.sv
// Status, enable and the derived pending bits, plus the register read mux.
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int N = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      set_vec,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [N-1:0]      pending,
    output logic [REG_W-1:0]  rdata
);

    logic [N-1:0] status_q;
    logic [N-1:0] enable_q;
    logic [N-1:0] ack_bits;
    logic         en_wr;

    assign en_wr    = we && (addr == ADR_ENABLE);
    assign ack_bits = (we && (addr == ADR_ACK)) ? wdata[N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~ack_bits) | set_vec;
            if (en_wr) enable_q <= wdata[N-1:0];
        end
    end

    assign pending = status_q & enable_q;

    always_comb begin
        unique case (reg_addr_e'(addr))
            ADR_STATUS: rdata = REG_W'(status_q);
            ADR_PEND:   rdata = REG_W'(pending);
            ADR_ENABLE: rdata = REG_W'(enable_q);
            ADR_ACK:    rdata = '0;
            default:    rdata = '0;
        endcase
    end

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_bits == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_ack_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_bits != '0) |=>
        ((status_q & $past(status_q) & ~$past(ack_bits)) == ($past(status_q) & ~$past(ack_bits))));

    assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    assert_en_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (enable_q == $past(wdata[N-1:0])));

    assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(enable_q));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int          EXT_COUNT = 8,
    parameter logic [15:0] EXT_EDGE  = 16'h000F,
    parameter logic [15:0] EXT_HIGH  = 16'h0033
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [FIXED+EXT_COUNT-1:0] irq_src,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    output logic                      irq_out
);

    localparam int          TOTAL    = FIXED + EXT_COUNT;
    localparam logic [31:0] EDGE32   = {EXT_EDGE, 16'hFFFF};
    localparam logic [31:0] HIGH32   = {EXT_HIGH, 16'hFFFF};
    localparam logic [TOTAL-1:0] EDGE_ALL = EDGE32[TOTAL-1:0];
    localparam logic [TOTAL-1:0] HIGH_ALL = HIGH32[TOTAL-1:0];

    if (EXT_COUNT > 16) begin : g_bad_count
        $error("EXT_COUNT must not exceed 16");
    end

    logic [TOTAL-1:0] norm;
    logic [TOTAL-1:0] set_vec;
    logic [TOTAL-1:0] pending;

    irq_input_sync #(.N(TOTAL), .ACT_HIGH(HIGH_ALL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (irq_src),
        .norm  (norm)
    );

    irq_capture #(.N(TOTAL), .EDGE_MODE(EDGE_ALL)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .norm    (norm),
        .set_vec (set_vec)
    );

    irq_regs #(.N(TOTAL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pending (pending),
        .rdata   (reg_rdata)
    );

    assign irq_out = |pending;

    assert_pend_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_PEND) |-> ((reg_rdata != '0) == irq_out));

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int N = 24;
    // Idle levels: active-low external lines 18,19,22,23 rest high.
    localparam logic [N-1:0] IDLE = 24'hCC0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = IDLE;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    irq_aggregator u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 20000", cycles);
            report();
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 status", v, 0);
        rd(2'd1, v); check("R1 pending", v, 0);
        rd(2'd2, v); check("R1 enable", v, 0);
        check("R1 irq_out", {31'd0, irq_out}, 0);
    endtask

    task automatic t_latency_edge();
        logic [31:0] v;
        irq_src[16] = 1'b1;
        wait_cyc(2);
        rd(2'd0, v); check("R11 not yet after two edges", v, 0);
        wait_cyc(1);
        rd(2'd0, v); check("R11 set after third edge", v, 32'h0001_0000);
        irq_src[16] = 1'b0;
        wait_cyc(5);
        rd(2'd0, v); check("R4 sticky after line idle", v, 32'h0001_0000);
        wr(2'd3, 32'h0001_0000);
        rd(2'd0, v); check("R4 cleared by ack", v, 0);
        irq_src[16] = 1'b1;
        wait_cyc(5);
        rd(2'd0, v); check("R4 held line sets once", v, 32'h0001_0000);
        wr(2'd3, 32'h0001_0000);
        wait_cyc(5);
        rd(2'd0, v); check("R4 held edge line not re-set", v, 0);
        irq_src[16] = 1'b0;
        wait_cyc(3);
    endtask

    task automatic t_level();
        logic [31:0] v;
        irq_src[20] = 1'b1;
        wait_cyc(3);
        rd(2'd0, v); check("R5 level source set", v, 32'h0010_0000);
        wr(2'd3, 32'h0010_0000);
        rd(2'd0, v); check("R8 level re-set during ack", v, 32'h0010_0000);
        irq_src[20] = 1'b0;
        wait_cyc(3);
        wr(2'd3, 32'h0010_0000);
        wait_cyc(2);
        rd(2'd0, v); check("R5 idle level stays clear", v, 0);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        irq_src[18] = 1'b0;
        irq_src[22] = 1'b0;
        irq_src[3]  = 1'b1;
        wait_cyc(1);
        irq_src[3]  = 1'b0;
        irq_src[18] = 1'b1;
        wait_cyc(2);
        rd(2'd0, v); check("R6 active-low edge, active-low level, fixed pulse", v, 32'h0044_0008);
        irq_src[22] = 1'b1;
        wait_cyc(3);
        rd(2'd0, v); check("R6 idle high lines add nothing", v, 32'h0044_0008);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        check("R2 no irq with enable clear", {31'd0, irq_out}, 0);
        wr(2'd2, 32'h0000_0008);
        check("R3 irq right after enable write", {31'd0, irq_out}, 1);
        rd(2'd1, v); check("R2 pending is status and enable", v, 32'h0000_0008);
        wr(2'd2, 32'h0000_0000);
        check("R3 irq drops right after enable clear", {31'd0, irq_out}, 0);
    endtask

    task automatic t_partial_ack();
        logic [31:0] v;
        wr(2'd3, 32'h0000_0108);
        rd(2'd0, v); check("R7 only written set bits cleared", v, 32'h0044_0000);
        rd(2'd3, v); check("R9 acknowledge reads zero", v, 0);
    endtask

    task automatic t_ignored_and_unused();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R9 status write ignored", v, 32'h0044_0000);
        rd(2'd2, v); check("R9 enable untouched by other writes", v, 0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R10 unused enable bits read zero", v, 32'h00FF_FFFF);
        rd(2'd1, v); check("R10 pending limited to used bits", v, 32'h0044_0000);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R7 ack all clears status", v, 0);
        check("R10 unused enable bits raise no irq", {31'd0, irq_out}, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_latency_edge();
        t_level();
        t_polarity();
        t_enable();
        t_partial_ack();
        t_ignored_and_unused();
        report();
    end

endmodule